// File: doc/BRIEF.md
# Bus Master Retry Controller

This block sequences the bus cycles of a 32-bit bus master. The core hands it one request at a time: address, function code, size, direction, and flags that mark a locked read-modify-write pair or a four-beat burst fill. The block drives an address strobe and the attributes for each beat. It then reads the slave's termination inputs: acknowledge, error, halt and a foreign bus request. From these it picks one of four outcomes: clean completion, bus error, halt, or retry.

On a retry the block drops every bus control output. It waits until the halt input has been seen low through a two-flop synchronizer, leaves one idle clock, and then reissues the same beat with identical attributes. Termination is checked twice for each beat: once while the strobe is high, and once in a check cycle straight after the acknowledge. This is how a late retry is still caught. A foreign bus request that arrives together with a retry makes the block grant the bus away before it retries. The exception is inside a locked pair, where the bus can only be given up during the read half.

When a request finishes, the block gives the core a one-cycle completion pulse with an error flag. It also keeps a status bit that tells whether the most recent bus error hit a locked read-modify-write pair.

Top module: `bm_retry_seq`

## Requirements
- R1: After a request is accepted, the strobe is high with the request's address, function code and size. An acknowledge with error and halt low, followed by a check cycle with error and halt low, ends the beat. On the last beat, `done` is high for exactly one cycle with `done_berr` low.
- R2: Error and halt sampled together while the strobe is high drop the strobe and the burst request on the next cycle.
- R3: After a retry, no strobe is issued while halt stays high. Let k be the first clock edge that samples halt low. The retried strobe rises after edge k+3.
- R4: A retried beat carries the same address, function code, size and direction as the beat it replaces.
- R5: Error and halt sampled together in the check cycle that follows an acknowledge also cause a retry.
- R6: A locked pair runs a read (`bus_rd`=1) and then a write (`bus_rd`=0). A retry reruns only the half it hit. `bus_rmc` stays high from the first strobe until the completion cycle, through any retry.
- R7: In a burst, `bus_breq` is high only with the strobe of the first beat. A retry of the first beat reissues it with `bus_breq` high. Beat i (0..3) puts base address bits [3:2] plus i, modulo 4, on address bits [3:2]; the other address bits are unchanged.
- R8: Error and halt together on burst beat 1, 2 or 3 do not cause a retry. No strobe is issued. After edge k+3 (k as in R3), `done` and `done_berr` are high, and no further strobe follows.
- R9: Bus request, error and halt together during a beat raise `bus_bg` with the strobe low for as long as the bus request stays high. After the bus request drops, the beat is retried.
- R10: During the write half of a locked pair, a bus request that comes with a retry is not honoured: `bus_bg` stays low, `bus_rmc` stays high, and the write is retried under the halt rule.
- R11: Error without halt ends the request with `done` and `done_berr` high. `berr_in_rmw` is loaded on every bus error with whether that request was a locked pair.
- R12: Halt without error in the check cycle after an acknowledge completes the beat, but the next beat waits until halt is released, with the timing of R3.
- R13: After reset, the strobe, `bus_rmc`, `bus_breq`, `bus_bg` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Block idle and accepting |
| req_addr | input | 32 | Request address |
| req_fc | input | 3 | Request function code |
| req_size | input | 2 | Request transfer size |
| req_rd | input | 1 | Read (1) or write (0); ignored for locked pairs |
| req_rmw | input | 1 | Locked read-modify-write pair |
| req_burst | input | 1 | Four-beat burst fill |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_berr | output | 1 | Request finished with bus error |
| berr_in_rmw | output | 1 | Last bus error hit a locked pair |
| bus_addr | output | 32 | Beat address |
| bus_fc | output | 3 | Function code |
| bus_size | output | 2 | Transfer size |
| bus_rd | output | 1 | Beat direction |
| bus_as | output | 1 | Address strobe |
| bus_rmc | output | 1 | Lock for read-modify-write pair |
| bus_breq | output | 1 | Burst request |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Bus error termination |
| bus_halt | input | 1 | Halt termination |
| bus_br | input | 1 | Foreign bus request |
| bus_bg | output | 1 | Bus granted away |

## Verification
The riskiest overlap is a retry that lands on the write half of a locked pair in the same cycle as a foreign bus request. In that cycle, the relinquish rule and the lock rule both claim the next state. The bench raises error, halt and bus request together while the write strobe is high. It then keeps the bus request high past the halt release. It judges the result at the ports: `bus_bg` must never rise, `bus_rmc` must stay high, and the strobe must come back as a write with the R3 timing. A second overlap is a late retry or halt arriving in the check cycle where a burst would step to its next beat; the bench checks the beat address after release.

// File: rtl/rtry_pkg.sv
package rtry_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_CYC, ST_LATE, ST_HOLD, ST_GAP, ST_REL} st_e;
  typedef enum logic [2:0] {OC_NONE, OC_ACK, OC_BERR, OC_HALT, OC_RETRY, OC_RELQ, OC_EHALT} oc_e;
  typedef enum logic [1:0] {HK_RETRY, HK_CONT, HK_BERR} hk_e;
endpackage

// File: rtl/rtry_sync.sv
module rtry_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic busy
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  // busy while any stage still carries a high level
  assign busy = |stg;
endmodule

// File: rtl/rtry_decode.sv
module rtry_decode
  import rtry_pkg::*;
(
  input  logic late,
  input  logic ack,
  input  logic err,
  input  logic halt,
  input  logic br,
  input  logic can_retry,
  input  logic can_rel,
  output oc_e  oc
);
  always_comb begin
    oc = OC_NONE;
    if (err && halt) begin
      if (!can_retry)         oc = OC_EHALT;
      else if (br && can_rel) oc = OC_RELQ;
      else                    oc = OC_RETRY;
    end else if (err) begin
      oc = OC_BERR;
    end else if (late) begin
      oc = halt ? OC_HALT : OC_ACK;
    end else if (ack) begin
      oc = OC_ACK;
    end
  end
endmodule

// File: rtl/bm_retry_seq.sv
module bm_retry_seq
  import rtry_pkg::*;
#(
  parameter int AW    = 32,
  parameter int FCW   = 3,
  parameter int SZW   = 2,
  parameter int BEATS = 4,
  parameter int SYNC  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [FCW-1:0] req_fc,
  input  logic [SZW-1:0] req_size,
  input  logic           req_rd,
  input  logic           req_rmw,
  input  logic           req_burst,
  output logic           done,
  output logic           done_berr,
  output logic           berr_in_rmw,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [SZW-1:0] bus_size,
  output logic           bus_rd,
  output logic           bus_as,
  output logic           bus_rmc,
  output logic           bus_breq,
  input  logic           bus_ack,
  input  logic           bus_err,
  input  logic           bus_halt,
  input  logic           bus_br,
  output logic           bus_bg
);
  localparam int BW = $clog2(BEATS);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  st_e            st, nst;
  hk_e            hk, nhk;
  oc_e            oc;
  logic [AW-1:0]  a_addr;
  logic [FCW-1:0] a_fc;
  logic [SZW-1:0] a_size;
  logic           a_rd, a_rmw, a_burst, phase;
  logic [BW-1:0]  beat;
  logic           done_q, berr_q, inrmw_q;
  logic           halt_busy, adv, ferr, cap;
  logic           can_retry, can_rel, more_beats, more_phase;
  logic [AW-1:0]  beat_addr;

  rtry_sync #(.STAGES(SYNC)) i_hsync (
    .clk(clk), .rst(rst), .d(bus_halt), .busy(halt_busy)
  );

  assign can_retry  = !(a_burst && beat != '0);
  assign can_rel    = !a_rmw || !phase;
  assign more_beats = a_burst && (beat != LAST_BEAT);
  assign more_phase = a_rmw && !phase;

  rtry_decode i_dec (
    .late(st == ST_LATE), .ack(bus_ack), .err(bus_err), .halt(bus_halt),
    .br(bus_br), .can_retry(can_retry), .can_rel(can_rel), .oc(oc)
  );

  // next-state selection
  always_comb begin
    nst = st; nhk = hk; adv = 1'b0; ferr = 1'b0; cap = 1'b0;
    case (st)
      ST_IDLE: if (req_valid && !halt_busy) begin cap = 1'b1; nst = ST_CYC; end
      ST_CYC, ST_LATE: begin
        case (oc)
          OC_ACK:   if (st == ST_CYC) nst = ST_LATE; else adv = 1'b1;
          OC_BERR:  ferr = 1'b1;
          OC_HALT:  begin nhk = HK_CONT;  nst = ST_HOLD; end
          OC_RETRY: begin nhk = HK_RETRY; nst = ST_HOLD; end
          OC_RELQ:  nst = ST_REL;
          OC_EHALT: begin nhk = HK_BERR;  nst = ST_HOLD; end
          default:  nst = st;
        endcase
      end
      ST_HOLD: if (!halt_busy) nst = ST_GAP;
      ST_GAP: begin
        if (halt_busy) nst = ST_HOLD;
        else begin
          case (hk)
            HK_RETRY: nst = ST_CYC;
            HK_CONT:  adv = 1'b1;
            default:  ferr = 1'b1;
          endcase
        end
      end
      ST_REL: if (!bus_br) begin nhk = HK_RETRY; nst = ST_HOLD; end
      default: nst = ST_IDLE;
    endcase
    if (adv)  nst = (more_beats || more_phase) ? ST_CYC : ST_IDLE;
    if (ferr) nst = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; hk <= HK_RETRY;
      a_addr <= '0; a_fc <= '0; a_size <= '0;
      a_rd <= 1'b0; a_rmw <= 1'b0; a_burst <= 1'b0;
      beat <= '0; phase <= 1'b0;
      done_q <= 1'b0; berr_q <= 1'b0; inrmw_q <= 1'b0;
    end else begin
      st <= nst;
      hk <= nhk;
      if (cap) begin
        a_addr <= req_addr; a_fc <= req_fc; a_size <= req_size;
        a_rd <= req_rd; a_rmw <= req_rmw; a_burst <= req_burst;
        beat <= '0; phase <= 1'b0;
      end
      if (adv) begin
        if (more_beats)      beat  <= beat + 1'b1;
        else if (more_phase) phase <= 1'b1;
      end
      done_q <= ferr || (adv && !more_beats && !more_phase);
      berr_q <= ferr;
      if (ferr) inrmw_q <= a_rmw;
    end
  end

  always_comb begin
    beat_addr = a_addr;
    beat_addr[BW+1:2] = a_addr[BW+1:2] + beat;
  end

  assign req_ready   = (st == ST_IDLE) && !halt_busy;
  assign bus_addr    = beat_addr;
  assign bus_fc      = a_fc;
  assign bus_size    = a_size;
  assign bus_rd      = a_rmw ? !phase : a_rd;
  assign bus_as      = (st == ST_CYC);
  assign bus_breq    = (st == ST_CYC) && a_burst && (beat == '0);
  assign bus_rmc     = a_rmw && (st != ST_IDLE) && (st != ST_REL);
  assign bus_bg      = (st == ST_REL);
  assign done        = done_q;
  assign done_berr   = berr_q;
  assign berr_in_rmw = inrmw_q;

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: retry on a live strobe quiets strobe and burst request
  p_retry_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_err && bus_halt) |=> (!bus_as && !bus_breq));
  // R3: a held halt keeps the strobe down
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && bus_halt) |=> !bus_as);
  // R4: the reissued strobe keeps the same address
  p_same_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP && hk == HK_RETRY && !halt_busy) |=> (bus_as && $stable(bus_addr)));
  // R6: the lock never drops mid-pair except by completion or grant
  p_lock_held_r6: assert property (@(posedge clk) disable iff (rst)
    bus_rmc |=> (bus_rmc || done || bus_bg));
  // R7: burst request only rides with a strobe
  p_breq_as_r7: assert property (@(posedge clk) disable iff (rst)
    bus_breq |-> bus_as);
  // R9: while granted away, the block drives no strobe and no lock
  p_grant_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    bus_bg |-> (!bus_as && !bus_rmc));
  // R10: no grant straight out of the write half of a locked pair
  p_no_rel_write_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_rmc && !bus_rd) |=> !bus_bg);
endmodule

// File: tb/test_bm_retry_seq.sv
module test_bm_retry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_fc = '0;
  logic [1:0]  req_size = '0;
  logic        req_rd = 1'b0, req_rmw = 1'b0, req_burst = 1'b0;
  logic        done, done_berr, berr_in_rmw;
  logic [31:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_size;
  logic        bus_rd, bus_as, bus_rmc, bus_breq, bus_bg;
  logic        bus_ack = 1'b0, bus_err = 1'b0, bus_halt = 1'b0, bus_br = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_retry_seq i_bm_retry_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size), .req_rd(req_rd),
    .req_rmw(req_rmw), .req_burst(req_burst), .done(done), .done_berr(done_berr),
    .berr_in_rmw(berr_in_rmw), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_size(bus_size), .bus_rd(bus_rd), .bus_as(bus_as), .bus_rmc(bus_rmc),
    .bus_breq(bus_breq), .bus_ack(bus_ack), .bus_err(bus_err), .bus_halt(bus_halt),
    .bus_br(bus_br), .bus_bg(bus_bg)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_attr(input string rq, input logic [31:0] a, input logic [2:0] f,
                          input logic [1:0] s, input logic r);
    chk(bus_as == 1'b1, rq, "strobe", 64'(bus_as), 64'd1);
    chk(bus_addr == a, rq, "addr", 64'(bus_addr), 64'(a));
    chk(bus_fc == f, rq, "fc", 64'(bus_fc), 64'(f));
    chk(bus_size == s, rq, "size", 64'(bus_size), 64'(s));
    chk(bus_rd == r, rq, "rd", 64'(bus_rd), 64'(r));
  endtask

  function automatic logic [31:0] beat_a(input logic [31:0] base, input int i);
    logic [31:0] r;
    r = base;
    r[3:2] = base[3:2] + 2'(i);
    return r;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [2:0] f, input logic [1:0] s,
                       input logic r, input logic m, input logic b);
    req_addr = a; req_fc = f; req_size = s; req_rd = r; req_rmw = m; req_burst = b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack_beat();
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  // drop halt; the strobe must stay low for three cycles, caller checks the fourth
  task automatic release_halt(input string rq);
    bus_halt = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bus_as == 1'b0, rq, "strobe before release delay", 64'(bus_as), 64'd0);
    end
    @(negedge clk);
  endtask

  task automatic finish_clean(input string rq);
    ack_beat();
    @(negedge clk);
    chk(done == 1'b1, rq, "done", 64'(done), 64'd1);
    chk(done_berr == 1'b0, rq, "done_berr", 64'(done_berr), 64'd0);
  endtask

  task automatic t_reset();
    chk(bus_as == 0, "R13", "as", 64'(bus_as), 0);
    chk(bus_rmc == 0, "R13", "rmc", 64'(bus_rmc), 0);
    chk(bus_breq == 0, "R13", "breq", 64'(bus_breq), 0);
    chk(bus_bg == 0, "R13", "bg", 64'(bus_bg), 0);
    chk(done == 0, "R13", "done", 64'(done), 0);
    chk(req_ready == 1, "R13", "ready", 64'(req_ready), 1);
  endtask

  task automatic t_single();
    issue(32'h0000_1234, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0);
    chk_attr("R1", 32'h0000_1234, 3'd5, 2'd2, 1'b1);
    finish_clean("R1");
    @(negedge clk);
    chk(done == 1'b0, "R1", "done pulse width", 64'(done), 0);
  endtask

  task automatic t_retry();
    issue(32'h2000_0040, 3'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    bus_err = 1'b1; bus_halt = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(bus_as == 1'b0, "R2", "strobe after retry", 64'(bus_as), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_as == 1'b0, "R3", "strobe while halt", 64'(bus_as), 0);
    end
    release_halt("R3");
    chk(bus_as == 1'b1, "R3", "strobe at release delay", 64'(bus_as), 1);
    chk_attr("R4", 32'h2000_0040, 3'd1, 2'd3, 1'b0);
    finish_clean("R4");
  endtask

  task automatic t_late();
    issue(32'h0000_0800, 3'd6, 2'd1, 1'b1, 1'b0, 1'b0);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0; bus_err = 1'b1; bus_halt = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(done == 1'b0, "R5", "no completion on late retry", 64'(done), 0);
    chk(bus_as == 1'b0, "R5", "strobe", 64'(bus_as), 0);
    @(negedge clk);
    release_halt("R5");
    chk_attr("R5", 32'h0000_0800, 3'd6, 2'd1, 1'b1);
    finish_clean("R5");
  endtask

  task automatic t_rmw();
    issue(32'h0000_0300, 3'd2, 2'd0, 1'b0, 1'b1, 1'b0);
    chk_attr("R6", 32'h0000_0300, 3'd2, 2'd0, 1'b1);
    chk(bus_rmc == 1'b1, "R6", "lock", 64'(bus_rmc), 1);
    bus_err = 1'b1; bus_halt = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(bus_rmc == 1'b1, "R6", "lock during read retry", 64'(bus_rmc), 1);
    release_halt("R6");
    chk(bus_rmc == 1'b1, "R6", "lock after release", 64'(bus_rmc), 1);
    chk_attr("R6", 32'h0000_0300, 3'd2, 2'd0, 1'b1);
    ack_beat();
    @(negedge clk);
    chk_attr("R6", 32'h0000_0300, 3'd2, 2'd0, 1'b0);
    bus_err = 1'b1; bus_halt = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(bus_rmc == 1'b1, "R6", "lock during write retry", 64'(bus_rmc), 1);
    release_halt("R6");
    chk_attr("R6", 32'h0000_0300, 3'd2, 2'd0, 1'b0);
    finish_clean("R6");
    chk(bus_rmc == 1'b0, "R6", "lock released at end", 64'(bus_rmc), 0);
  endtask

  task automatic t_burst_retry();
    logic [31:0] base = 32'h1000_0008;
    issue(base, 3'd6, 2'd3, 1'b1, 1'b0, 1'b1);
    chk(bus_breq == 1'b1, "R7", "breq beat0", 64'(bus_breq), 1);
    chk_attr("R7", beat_a(base, 0), 3'd6, 2'd3, 1'b1);
    bus_err = 1'b1; bus_halt = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(bus_breq == 1'b0, "R2", "breq after retry", 64'(bus_breq), 0);
    release_halt("R7");
    chk(bus_breq == 1'b1, "R7", "breq on retried beat0", 64'(bus_breq), 1);
    for (int i = 0; i < 4; i++) begin
      ack_beat();
      @(negedge clk);
      if (i < 3) begin
        chk_attr("R7", beat_a(base, i + 1), 3'd6, 2'd3, 1'b1);
        chk(bus_breq == 1'b0, "R7", "breq later beat", 64'(bus_breq), 0);
      end else begin
        chk(done == 1'b1 && done_berr == 1'b0, "R7", "burst done", 64'({done, done_berr}), 64'h2);
      end
    end
  endtask

  task automatic t_burst_beat2();
    logic [31:0] base = 32'h0000_5004;
    issue(base, 3'd2, 2'd3, 1'b1, 1'b0, 1'b1);
    ack_beat(); @(negedge clk);
    ack_beat(); @(negedge clk);
    chk_attr("R8", beat_a(base, 2), 3'd2, 2'd3, 1'b1);
    bus_err = 1'b1; bus_halt = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bus_as == 1'b0 && done == 1'b0, "R8", "quiet while halt", 64'({bus_as, done}), 0);
    end
    release_halt("R8");
    chk(done == 1'b1 && done_berr == 1'b1, "R8", "error end", 64'({done, done_berr}), 64'h3);
    chk(bus_as == 1'b0, "R8", "no retry strobe", 64'(bus_as), 0);
    chk(berr_in_rmw == 1'b0, "R11", "rmw status on burst", 64'(berr_in_rmw), 0);
    @(negedge clk);
    chk(bus_as == 1'b0, "R8", "no later strobe", 64'(bus_as), 0);
  endtask

  task automatic t_rel();
    issue(32'h0000_0A00, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0);
    bus_err = 1'b1; bus_halt = 1'b1; bus_br = 1'b1;
    @(negedge clk);
    bus_err = 1'b0; bus_halt = 1'b0;
    chk(bus_bg == 1'b1 && bus_as == 1'b0, "R9", "granted", 64'({bus_bg, bus_as}), 64'h2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_bg == 1'b1 && bus_as == 1'b0, "R9", "grant held", 64'({bus_bg, bus_as}), 64'h2);
    end
    bus_br = 1'b0;
    @(negedge clk);
    chk(bus_bg == 1'b0, "R9", "grant dropped", 64'(bus_bg), 0);
    @(negedge clk);
    @(negedge clk);
    chk_attr("R9", 32'h0000_0A00, 3'd5, 2'd2, 1'b1);
    finish_clean("R9");
  endtask

  task automatic t_rmw_rel_write();
    issue(32'h0000_0C10, 3'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    ack_beat(); @(negedge clk);
    chk(bus_rd == 1'b0 && bus_as == 1'b1, "R10", "write half", 64'({bus_rd, bus_as}), 64'h1);
    bus_err = 1'b1; bus_halt = 1'b1; bus_br = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(bus_bg == 1'b0 && bus_rmc == 1'b1, "R10", "no grant, lock kept", 64'({bus_bg, bus_rmc}), 64'h1);
    @(negedge clk);
    @(negedge clk);
    chk(bus_bg == 1'b0, "R10", "no grant later", 64'(bus_bg), 0);
    release_halt("R10");
    chk_attr("R10", 32'h0000_0C10, 3'd1, 2'd1, 1'b0);
    chk(bus_bg == 1'b0 && bus_rmc == 1'b1, "R10", "retry under lock", 64'({bus_bg, bus_rmc}), 64'h1);
    bus_br = 1'b0;
    finish_clean("R10");
  endtask

  task automatic t_berr();
    issue(32'h0000_0E00, 3'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    ack_beat(); @(negedge clk);
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(done == 1'b1 && done_berr == 1'b1, "R11", "error end rmw", 64'({done, done_berr}), 64'h3);
    chk(berr_in_rmw == 1'b1, "R11", "rmw status set", 64'(berr_in_rmw), 1);
    @(negedge clk);
    issue(32'h0000_0F00, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0);
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    chk(done == 1'b1 && done_berr == 1'b1, "R11", "error end single", 64'({done, done_berr}), 64'h3);
    chk(berr_in_rmw == 1'b0, "R11", "rmw status cleared", 64'(berr_in_rmw), 0);
  endtask

  task automatic t_halt_only();
    logic [31:0] base = 32'h0000_7000;
    issue(base, 3'd6, 2'd3, 1'b1, 1'b0, 1'b1);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0; bus_halt = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bus_as == 1'b0, "R12", "next beat held", 64'(bus_as), 0);
    end
    release_halt("R12");
    chk_attr("R12", beat_a(base, 1), 3'd6, 2'd3, 1'b1);
    chk(bus_breq == 1'b0, "R12", "breq after halt", 64'(bus_breq), 0);
    ack_beat(); @(negedge clk);
    ack_beat(); @(negedge clk);
    finish_clean("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();       @(negedge clk);
    t_retry();        @(negedge clk);
    t_late();         @(negedge clk);
    t_rmw();          @(negedge clk);
    t_burst_retry();  @(negedge clk);
    t_burst_beat2();  @(negedge clk);
    t_rel();          @(negedge clk);
    t_rmw_rel_write(); @(negedge clk);
    t_berr();         @(negedge clk);
    t_halt_only();    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule